// File: doc/BRIEF.md
# Cascadable byte scan readout multiplexer

This block reads a 40-bit captured value out over an 8-bit bus, one byte per strobe, lowest byte first. An external scan strobe paces the readout: while the strobe is high the block drives the byte chosen by its scan sequencer. Each falling edge of the strobe moves the sequencer to the next byte. After the fifth byte the sequencer enters a terminal state. There it stops driving and releases its cascade output.

The cascade output of one instance feeds the active-low enable of the next. Several instances that share the strobe, the scan-reset/load line and the byte bus therefore drive the bus one after another. A low level on the scan-reset/load line rewinds every sequencer to the first byte and raises a load request toward the capture latch. The captured value arrives as an input vector. The three control inputs are asynchronous and pass through a two-flop synchronizer on the system clock. Output-enable stands in for three-state drive, and data is zero whenever output-enable is low.

Top module: `byte_scan_mux`

## Requirements
- R1: Throughout reset and after it, with no stimulus, `casc_en_o` is 1, `data_oe_o` is 0, `data_o` is 0 and `load_req_o` is 0.
- R2: Each of `scan_i`, `scan_rst_load_n_i` and `en_n_i` passes through two flops. A level change sampled at rising edge k affects the output-enable and the load request after edge k+1. A falling scan edge moves the sequencer at edge k+2.
- R3: While the synchronized `scan_rst_load_n_i` is 0, `load_req_o` is 1 and the sequencer returns to the first byte position, whatever the other inputs are doing.
- R4: The sequencer advances one position on each synchronized falling edge of `scan_i`, but only while the synchronized `en_n_i` is 0. Edges seen while enable is high leave the position unchanged.
- R5: The sequencer has six positions. Positions 1 to 5 select bytes, and position 6 is terminal. Once in position 6 the sequencer ignores further scan edges until the next scan-reset.
- R6: `data_oe_o` is 1 only when the synchronized scan is 1, the synchronized enable is 0 and the position is not 6. When `data_oe_o` is 0, `data_o` is 0.
- R7: Position n (1 to 5) drives bits 8n-1 down to 8n-8 of `latch_val_i`. Position 1 drives bits 7:0.
- R8: `casc_en_o` is 1 in positions 1 to 5, goes to 0 on entering position 6 and stays 0, and returns to 1 when a scan-reset is applied.
- R9: Three instances chained through `casc_en_o` to the next `en_n_i` put 15 bytes on a shared bus, device by device and lowest byte first. No two output-enables are ever 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| latch_val_i | input | 40 | Captured value to read out (NUM_BYTES*BYTE_W) |
| scan_i | input | 1 | Scan strobe, asynchronous |
| scan_rst_load_n_i | input | 1 | Active-low scan-reset and latch load request, asynchronous |
| en_n_i | input | 1 | Active-low enable, asynchronous, fed by the previous device's cascade output |
| data_o | output | 8 | Selected byte, zero when not driving |
| data_oe_o | output | 1 | Output-enable for the shared bus |
| casc_en_o | output | 1 | Cascade output, low once the terminal position is reached |
| load_req_o | output | 1 | Load request to the capture latch |

## Verification
The assertions assume that the strobe stays at each level for several clocks. This way every falling edge shows up as one synchronized event, and the cascade hand-over to the next device settles while the strobe is still low. They also assume that enable changes only while the strobe is low. The stimulus holds the strobe high and low for eight clocks each, changes the first device's enable only during low phases, and keeps each scan-reset low for six clocks. A behavioural model in the bench tracks every device's position and predicts all four outputs on each clock.

// File: rtl/bsm_pkg.sv
package bsm_pkg;

  typedef struct packed {
    logic scan;
    logic rl_n;
    logic en_n;
  } bsm_ctl_t;

  // Next sequencer position: a clear wins, then a step, else hold.
  function automatic int unsigned bsm_next_pos(input int unsigned cur,
                                               input logic step,
                                               input logic clear);
    int unsigned nxt;
    nxt = cur;
    if (clear)     nxt = 0;
    else if (step) nxt = cur + 1;
    return nxt;
  endfunction

endpackage

// File: rtl/bsm_sync.sv
module bsm_sync #(
  parameter int          WIDTH   = 3,
  parameter int          STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] pipe [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (!rst_n) pipe[g] <= RST_VAL;
        else        pipe[g] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (!rst_n) pipe[g] <= RST_VAL;
        else        pipe[g] <= pipe[g-1];
      end
    end
  end

  assign q_o = pipe[STAGES-1];
endmodule

// File: rtl/bsm_seq.sv
module bsm_seq
  import bsm_pkg::*;
#(
  parameter int NUM_BYTES = 5,
  localparam int SEL_W    = $clog2(NUM_BYTES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scan_s_i,
  input  logic             clear_i,
  input  logic             en_i,
  output logic [SEL_W-1:0] pos_o,
  output logic             term_o,
  output logic             fall_o,
  output logic             step_o
);
  localparam logic [SEL_W-1:0] TERM_POS = SEL_W'(NUM_BYTES);

  logic             scan_prev;
  logic [SEL_W-1:0] pos_q;

  always_ff @(posedge clk) begin
    if (!rst_n) scan_prev <= 1'b0;
    else        scan_prev <= scan_s_i;
  end

  assign fall_o = scan_prev & ~scan_s_i;
  assign term_o = (pos_q == TERM_POS);
  assign step_o = fall_o & en_i & ~term_o & ~clear_i;

  always_ff @(posedge clk) begin
    if (!rst_n) pos_q <= '0;
    else        pos_q <= SEL_W'(bsm_next_pos(int'(pos_q), step_o, clear_i));
  end

  assign pos_o = pos_q;
endmodule

// File: rtl/bsm_drive.sv
module bsm_drive #(
  parameter int BYTE_W    = 8,
  parameter int NUM_BYTES = 5,
  localparam int SEL_W    = $clog2(NUM_BYTES + 1),
  localparam int VAL_W    = BYTE_W * NUM_BYTES
) (
  input  logic [VAL_W-1:0]  val_i,
  input  logic [SEL_W-1:0]  pos_i,
  input  logic              scan_s_i,
  input  logic              en_i,
  input  logic              term_i,
  output logic [BYTE_W-1:0] data_o,
  output logic              oe_o
);
  logic [BYTE_W-1:0] lanes [NUM_BYTES];

  for (genvar g = 0; g < NUM_BYTES; g++) begin : g_lane
    assign lanes[g] = val_i[g*BYTE_W +: BYTE_W];
  end

  assign oe_o = scan_s_i & en_i & ~term_i;

  always_comb begin
    data_o = '0;
    for (int i = 0; i < NUM_BYTES; i++) begin
      if (oe_o && pos_i == SEL_W'(i)) data_o = lanes[i];
    end
  end
endmodule

// File: rtl/byte_scan_mux.sv
module byte_scan_mux
  import bsm_pkg::*;
#(
  parameter int BYTE_W      = 8,
  parameter int NUM_BYTES   = 5,
  parameter int SYNC_STAGES = 2,
  localparam int SEL_W      = $clog2(NUM_BYTES + 1),
  localparam int VAL_W      = BYTE_W * NUM_BYTES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [VAL_W-1:0]  latch_val_i,
  input  logic              scan_i,
  input  logic              scan_rst_load_n_i,
  input  logic              en_n_i,
  output logic [BYTE_W-1:0] data_o,
  output logic              data_oe_o,
  output logic              casc_en_o,
  output logic              load_req_o
);
  localparam bsm_ctl_t CTL_IDLE = '{scan: 1'b0, rl_n: 1'b1, en_n: 1'b1};

  bsm_ctl_t         ctl_raw, ctl_s;
  logic [SEL_W-1:0] pos_w;
  logic             term_w, fall_w, step_w, en_w, clear_w;

  assign ctl_raw = '{scan: scan_i, rl_n: scan_rst_load_n_i, en_n: en_n_i};

  bsm_sync #(.WIDTH($bits(bsm_ctl_t)), .STAGES(SYNC_STAGES), .RST_VAL(CTL_IDLE)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(ctl_raw), .q_o(ctl_s)
  );

  assign en_w    = ~ctl_s.en_n;
  assign clear_w = ~ctl_s.rl_n;

  bsm_seq #(.NUM_BYTES(NUM_BYTES)) u_seq (
    .clk(clk), .rst_n(rst_n), .scan_s_i(ctl_s.scan), .clear_i(clear_w),
    .en_i(en_w), .pos_o(pos_w), .term_o(term_w), .fall_o(fall_w), .step_o(step_w)
  );

  bsm_drive #(.BYTE_W(BYTE_W), .NUM_BYTES(NUM_BYTES)) u_drive (
    .val_i(latch_val_i), .pos_i(pos_w), .scan_s_i(ctl_s.scan), .en_i(en_w),
    .term_i(term_w), .data_o(data_o), .oe_o(data_oe_o)
  );

  assign casc_en_o  = ~term_w;
  assign load_req_o = clear_w;
endmodule

// File: rtl/bsm_chk.sv
module bsm_chk #(
  parameter int SEL_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             data_oe_o,
  input logic             casc_en_o,
  input logic             load_req_o,
  input logic [SEL_W-1:0] pos_w,
  input logic             fall_w,
  input logic             step_w,
  input logic             en_w
);
  // R6
  oe_only_before_term_chk: assert property (@(posedge clk) disable iff (!rst_n)
    data_oe_o |-> casc_en_o);

  // R8
  casc_stays_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!casc_en_o && !load_req_o) |=> !casc_en_o);

  // R3
  clear_rewinds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_req_o |=> (pos_w == '0 && casc_en_o));

  // R4
  step_increments_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_w |=> pos_w == $past(pos_w) + 1'b1);

  // R5
  no_edge_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!fall_w && !load_req_o) |=> $stable(pos_w));

  // R4
  disabled_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_w && !load_req_o) |=> $stable(pos_w));
endmodule

bind byte_scan_mux bsm_chk #(.SEL_W(SEL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .data_oe_o(data_oe_o), .casc_en_o(casc_en_o),
  .load_req_o(load_req_o), .pos_w(pos_w), .fall_w(fall_w), .step_w(step_w), .en_w(en_w)
);

// File: tb/sim_byte_scan_mux.sv
module sim_byte_scan_mux;
  localparam int NDEV = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scan = 1'b0;
  logic rl_n = 1'b1;
  logic en0_n = 1'b0;
  logic [39:0] lat [NDEV];
  logic [7:0]  dat [NDEV];
  logic        oe [NDEV], casc [NDEV], lreq [NDEV];

  always #4 clk = ~clk;  // 125 MHz

  int checks = 0;
  int errors = 0;

  initial begin
    for (int k = 0; k < NDEV; k++)
      for (int b = 0; b < 5; b++) lat[k][b*8 +: 8] = 8'(16 * (k + 1) + b);
  end

  byte_scan_mux u0 (.clk(clk), .rst_n(rst_n), .latch_val_i(lat[0]), .scan_i(scan),
    .scan_rst_load_n_i(rl_n), .en_n_i(en0_n), .data_o(dat[0]), .data_oe_o(oe[0]),
    .casc_en_o(casc[0]), .load_req_o(lreq[0]));
  byte_scan_mux u1 (.clk(clk), .rst_n(rst_n), .latch_val_i(lat[1]), .scan_i(scan),
    .scan_rst_load_n_i(rl_n), .en_n_i(casc[0]), .data_o(dat[1]), .data_oe_o(oe[1]),
    .casc_en_o(casc[1]), .load_req_o(lreq[1]));
  byte_scan_mux u2 (.clk(clk), .rst_n(rst_n), .latch_val_i(lat[2]), .scan_i(scan),
    .scan_rst_load_n_i(rl_n), .en_n_i(casc[1]), .data_o(dat[2]), .data_oe_o(oe[2]),
    .casc_en_o(casc[2]), .load_req_o(lreq[2]));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Behavioural reference: positions 0..5 (5 = terminal), inputs seen two clocks late.
  int m_pos [NDEV];
  bit sq [$], rq [$];
  bit eq1 [NDEV], eq2 [NDEV];
  bit s_prev;

  always @(posedge clk) begin
    int nxt [NDEV];
    bit en_raw [NDEV];
    bit fell;
    if (!rst_n) begin
      for (int k = 0; k < NDEV; k++) begin m_pos[k] = 0; eq1[k] = 1; eq2[k] = 1; end
      sq = '{0, 0}; rq = '{1, 1}; s_prev = 0;
    end else begin
      fell = s_prev && !sq[0];
      for (int k = 0; k < NDEV; k++) begin
        en_raw[k] = (k == 0) ? en0_n : (m_pos[k-1] != 5);
        if (!rq[0])                              nxt[k] = 0;
        else if (fell && !eq2[k] && m_pos[k] != 5) nxt[k] = m_pos[k] + 1;
        else                                     nxt[k] = m_pos[k];
      end
      s_prev = sq[0];
      void'(sq.pop_front()); sq.push_back(scan);
      void'(rq.pop_front()); rq.push_back(rl_n);
      for (int k = 0; k < NDEV; k++) begin
        eq2[k] = eq1[k]; eq1[k] = en_raw[k]; m_pos[k] = nxt[k];
      end
    end
  end

  logic [7:0] seen [$];
  bit prev_bus_oe = 0;
  int overlap = 0;
  int oe_events = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      bit bus_oe;
      bit e_oe;
      logic [7:0] bus;
      bus = 8'h00; bus_oe = 0;
      for (int k = 0; k < NDEV; k++) begin
        e_oe = sq[0] && !eq2[k] && m_pos[k] != 5;
        chk("R2 R6 model oe", 32'(oe[k]), 32'(e_oe));
        chk("R7 model data", 32'(dat[k]), e_oe ? 32'(16 * (k + 1) + m_pos[k]) : 32'd0);
        chk("R8 model casc", 32'(casc[k]), 32'(m_pos[k] != 5));
        chk("R3 model load", 32'(lreq[k]), 32'(!rq[0]));
        bus = bus | dat[k];
        bus_oe = bus_oe | oe[k];
      end
      if ($countones({oe[0], oe[1], oe[2]}) > 1) overlap++;
      if (bus_oe && !prev_bus_oe) begin seen.push_back(bus); oe_events++; end
      prev_bus_oe = bus_oe;
    end
  end

  task automatic pulse();
    scan = 1'b1; repeat (8) @(negedge clk);
    scan = 1'b0; repeat (8) @(negedge clk);
  endtask

  task automatic scan_reset();
    rl_n = 1'b0; repeat (3) @(negedge clk);
    for (int k = 0; k < NDEV; k++) chk("R3 load request", 32'(lreq[k]), 32'd1);
    repeat (3) @(negedge clk);
    rl_n = 1'b1; repeat (4) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    for (int k = 0; k < NDEV; k++) begin
      chk("R1 reset casc", 32'(casc[k]), 32'd1);
      chk("R1 reset oe", 32'(oe[k]), 32'd0);
      chk("R1 reset data", 32'(dat[k]), 32'd0);
      chk("R1 reset load", 32'(lreq[k]), 32'd0);
    end
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    scan_reset();

    // R4: strobes while the head device is disabled move nothing and drive nothing
    en0_n = 1'b1; repeat (4) @(negedge clk);
    pulse(); pulse();
    chk("R6 no drive while disabled", 32'(oe_events), 32'd0);
    en0_n = 1'b0; repeat (4) @(negedge clk);

    // R9: fifteen bytes in device order, lowest byte first
    seen.delete();
    for (int i = 0; i < 15; i++) pulse();
    chk("R9 byte count", 32'(seen.size()), 32'd15);
    for (int i = 0; i < 15 && i < seen.size(); i++)
      chk("R7 R4 byte order", 32'(seen[i]), 32'(16 * (i / 5 + 1) + i % 5));
    chk("R9 no overlap", 32'(overlap), 32'd0);
    chk("R8 last casc low", 32'(casc[2]), 32'd0);

    // R5: terminal position ignores further strobes
    pulse(); pulse();
    chk("R5 terminal ignores scan", 32'(seen.size()), 32'd15);
    chk("R5 head casc held", 32'(casc[0]), 32'd0);

    // R8 / R3: scan-reset restores cascade and rewinds to the first byte
    scan_reset();
    for (int k = 0; k < NDEV; k++) chk("R8 casc after reset", 32'(casc[k]), 32'd1);
    pulse();
    chk("R3 first byte after rewind", 32'(seen[seen.size()-1]), 32'h10);
    chk("R9 no overlap end", 32'(overlap), 32'd0);
    finish_run();
  end
endmodule